// File: doc/BRIEF.md
# SMBus Transaction Register Engine

This block is the transaction layer of an SMBus host controller. Software fills a small byte-addressed register bank (target address, command byte, byte count and a 32-byte data buffer) and then writes a protocol code. That single write launches a complete SMBus transaction. The engine walks through its byte-level steps: start, address byte, command, count, data, repeated start, receive and stop. It hands each step to an external bit-level bus engine and finally posts a DONE flag with a 5-bit result code in the status register.

The bus-engine side is a valid/ready stream of operations. The engine raises `op_valid` with `op_kind`, `op_byte` and `op_nack`, and holds all of them unchanged until a cycle with `op_ready` high completes the step. The bus engine applies back-pressure by keeping `op_ready` low for as long as it needs. In the completing cycle it also presents `op_rbyte` (the received byte, for receive steps) and `op_nak` (the target did not acknowledge, for send steps). The operation kinds are start 0, send 1, receive 2, repeated start 3 and stop 4. Register-port reads are combinational, and writes take effect at the clock edge.

Top module: `smbus_xact_engine`

## Requirements
- R1: After reset every register reads 0. The byte port holds protocol at 0x00, status at 0x01, target address at 0x02, command at 0x03, data bytes at 0x04..0x23, byte count at 0x24 and alarm storage at 0x25..0x27. Writable registers read back what was written.
- R2: Once `op_valid` is raised, the step's kind, byte and nack flag stay unchanged until the cycle in which `op_ready` is high, and exactly one step completes per such cycle.
- R3: Bit 7 is masked off before the protocol code is decoded. The code then selects the step list. 0x02/0x03 quick: start, address, stop. 0x04 byte send: start, address, command, stop. 0x05 byte receive: start, address, one receive, stop. 0x06 and 0x08 send the command and then one and two data bytes. 0x07 and 0x09 send the command, issue a repeated start and the address again, then receive one and two bytes.
- R4: 0x0A block write sends the command, the count and then the data bytes. 0x0B block read sends the command, repeats the start and receives a count and then that many bytes. 0x0C process call sends the command and two data bytes, repeats the start and receives two bytes. 0x0D block process call sends the command, the count and the data, repeats the start and receives a count and then the data.
- R5: 0x4A raw block write sends the command and then the byte-count register's number of data bytes, with no count byte. 0x4B raw block read sends the command, repeats the start and receives the byte-count register's number of bytes, with no count from the target.
- R6: Each address byte is the address register with bit 0 replaced. It is 1 for the receive direction (the address after a repeated start, and the only address of 0x03 and 0x05) and 0 otherwise.
- R7: Received bytes fill the data buffer from data byte 0 in arrival order, so a word lands low byte first. Only the last receive step of a transaction carries `op_nack` = 1.
- R8: The outgoing block length is the byte count clamped to 32. For 0x0D it is clamped to 31. The count byte that is sent is the clamped value.
- R9: A received block count from 1 to 32 is written into the byte-count register. A count of 0 or above 32 ends the transaction with a stop and result code 0x11.
- R10: A not-acknowledged address byte ends the transaction with a stop and code 0x10. A not-acknowledged command, count or data byte ends it with a stop and code 0x11.
- R11: An accepted protocol write clears DONE and the result code at once. The edge that completes the stop step sets DONE (status bit 7) with code 0x00 on success. The status byte is {DONE, 0, 0, code}.
- R12: While a transaction runs, a protocol write sets the code to 0x1A and leaves DONE clear, and all register writes are ignored. The running transaction and the protocol register are unaffected.
- R13: An unrecognised protocol code sets DONE with code 0x19 one edge after the write and issues no bus step.
- R14: `pec_req` is high while a transaction launched with protocol bit 7 set is running, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| op_valid | output | 1 | Bus step offered |
| op_ready | input | 1 | Bus engine completes the offered step |
| op_kind | output | 3 | Step kind: 0 start, 1 send, 2 receive, 3 repeated start, 4 stop |
| op_byte | output | 8 | Byte to send |
| op_nack | output | 1 | Receive step is the last one (master NACK) |
| op_rbyte | input | 8 | Received byte, valid with op_ready |
| op_nak | input | 1 | Target did not acknowledge the sent byte, valid with op_ready |
| pec_req | output | 1 | Running transaction asks for PEC |

## Verification
A rejected protocol write is visible one edge after the write: code 0x1A for a busy write, and DONE with 0x19 for an unknown code. The bench therefore reads status at the falling edge right after the writing edge. A successful or failed transaction posts its status on the edge that completes the stop step, which depends on how long the bus model stalls. So the bench polls the status register until DONE and only then compares the status, the step count, the logged address and data bytes and the data buffer. `pec_req` is sampled mid-run and again after DONE.

// File: rtl/smbx_pkg.sv
package smbx_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_SEND   = 3'd1,
    OP_RECV   = 3'd2,
    OP_RSTART = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  localparam logic [4:0] RC_OK     = 5'h00;
  localparam logic [4:0] RC_NAK    = 5'h10;
  localparam logic [4:0] RC_DEVERR = 5'h11;
  localparam logic [4:0] RC_UNSUP  = 5'h19;
  localparam logic [4:0] RC_BUSY   = 5'h1A;

  typedef struct packed {
    logic       valid;
    logic       first_rd;
    logic       send_cmd;
    logic       send_cnt;
    logic       rx_en;
    logic       rx_cnt;
    logic [7:0] nwr;
    logic [7:0] nrd;
  } xact_desc_t;
endpackage

// File: rtl/smbx_decode.sv
module smbx_decode
  import smbx_pkg::*;
#(
  parameter int DATA_BYTES = 32
) (
  input  logic [7:0]  code,
  input  logic [7:0]  cnt_reg,
  output xact_desc_t  desc
);
  localparam logic [7:0] LIM_FULL  = 8'(DATA_BYTES);
  localparam logic [7:0] LIM_SHORT = 8'(DATA_BYTES - 1);

  logic [6:0] c;
  logic [7:0] len_full, len_short;

  assign c         = code[6:0];
  assign len_full  = (cnt_reg > LIM_FULL)  ? LIM_FULL  : cnt_reg;
  assign len_short = (cnt_reg > LIM_SHORT) ? LIM_SHORT : cnt_reg;

  always_comb begin
    desc       = '0;
    desc.valid = 1'b1;
    case (c)
      7'h02, 7'h03: desc.first_rd = c[0];
      7'h04: desc.send_cmd = 1'b1;
      7'h05: begin desc.first_rd = 1'b1; desc.rx_en = 1'b1; desc.nrd = 8'd1; end
      7'h06: begin desc.send_cmd = 1'b1; desc.nwr = 8'd1; end
      7'h07: begin desc.send_cmd = 1'b1; desc.rx_en = 1'b1; desc.nrd = 8'd1; end
      7'h08: begin desc.send_cmd = 1'b1; desc.nwr = 8'd2; end
      7'h09: begin desc.send_cmd = 1'b1; desc.rx_en = 1'b1; desc.nrd = 8'd2; end
      7'h0A: begin desc.send_cmd = 1'b1; desc.send_cnt = 1'b1; desc.nwr = len_full; end
      7'h0B: begin desc.send_cmd = 1'b1; desc.rx_en = 1'b1; desc.rx_cnt = 1'b1; end
      7'h0C: begin
        desc.send_cmd = 1'b1; desc.nwr = 8'd2; desc.rx_en = 1'b1; desc.nrd = 8'd2;
      end
      7'h0D: begin
        desc.send_cmd = 1'b1; desc.send_cnt = 1'b1; desc.nwr = len_short;
        desc.rx_en = 1'b1; desc.rx_cnt = 1'b1;
      end
      7'h4A: begin desc.send_cmd = 1'b1; desc.nwr = len_full; end
      7'h4B: begin desc.send_cmd = 1'b1; desc.rx_en = 1'b1; desc.nrd = len_full; end
      default: desc.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/smbx_regfile.sv
module smbx_regfile #(
  parameter int DATA_BYTES = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic          host_we,
  input  logic          idle,
  output logic [7:0]    host_rdata,
  input  logic [7:0]    sts_byte,
  output logic [7:0]    prot_q,
  output logic [7:0]    addr_q,
  output logic [7:0]    cmd_q,
  output logic [7:0]    bcnt_q,
  input  logic [7:0]    tx_idx,
  output logic [7:0]    tx_byte,
  input  logic          eng_dwe,
  input  logic [7:0]    eng_didx,
  input  logic [7:0]    eng_dbyte,
  input  logic          eng_cwe,
  input  logic [7:0]    eng_cnt
);
  localparam int IW     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam int A_DATA = 4;
  localparam int A_BCNT = A_DATA + DATA_BYTES;
  localparam int A_ALA  = A_BCNT + 1;
  localparam int A_ALD0 = A_BCNT + 2;
  localparam int A_ALD1 = A_BCNT + 3;

  logic [7:0] mem [DATA_BYTES];
  logic [7:0] ala_q, ald0_q, ald1_q;
  logic       wr_ok, in_data;
  logic [AW-1:0] off;

  assign wr_ok   = host_we && idle;
  assign off     = host_addr - AW'(A_DATA);
  assign in_data = (host_addr >= AW'(A_DATA)) && (host_addr < AW'(A_BCNT));
  assign tx_byte = mem[tx_idx[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0; addr_q <= '0; cmd_q <= '0; bcnt_q <= '0;
      ala_q <= '0; ald0_q <= '0; ald1_q <= '0;
      for (int i = 0; i < DATA_BYTES; i++) mem[i] <= '0;
    end else begin
      if (wr_ok) begin
        if (host_addr == AW'(0))      prot_q <= host_wdata;
        if (host_addr == AW'(2))      addr_q <= host_wdata;
        if (host_addr == AW'(3))      cmd_q  <= host_wdata;
        if (host_addr == AW'(A_BCNT)) bcnt_q <= host_wdata;
        if (host_addr == AW'(A_ALA))  ala_q  <= host_wdata;
        if (host_addr == AW'(A_ALD0)) ald0_q <= host_wdata;
        if (host_addr == AW'(A_ALD1)) ald1_q <= host_wdata;
        if (in_data) mem[off[IW-1:0]] <= host_wdata;
      end
      if (eng_dwe) mem[eng_didx[IW-1:0]] <= eng_dbyte;
      if (eng_cwe) bcnt_q <= eng_cnt;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (in_data)                        host_rdata = mem[off[IW-1:0]];
    else if (host_addr == AW'(0))       host_rdata = prot_q;
    else if (host_addr == AW'(1))       host_rdata = sts_byte;
    else if (host_addr == AW'(2))       host_rdata = addr_q;
    else if (host_addr == AW'(3))       host_rdata = cmd_q;
    else if (host_addr == AW'(A_BCNT))  host_rdata = bcnt_q;
    else if (host_addr == AW'(A_ALA))   host_rdata = ala_q;
    else if (host_addr == AW'(A_ALD0))  host_rdata = ald0_q;
    else if (host_addr == AW'(A_ALD1))  host_rdata = ald1_q;
  end

  // R12: host writes must not land in storage while a run is in progress
  assert_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !idle && host_addr == AW'(3)) |=> $stable(cmd_q));
endmodule

// File: rtl/smbx_seq.sv
module smbx_seq
  import smbx_pkg::*;
#(
  parameter int DATA_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_we,
  input  xact_desc_t  desc,
  input  logic [7:0]  addr_q,
  input  logic [7:0]  cmd_q,
  input  logic [7:0]  tx_byte,
  output logic [7:0]  tx_idx,
  output logic        op_valid,
  input  logic        op_ready,
  output bus_op_e     op_kind,
  output logic [7:0]  op_byte,
  output logic        op_nack,
  input  logic [7:0]  op_rbyte,
  input  logic        op_nak,
  output logic        eng_dwe,
  output logic [7:0]  eng_didx,
  output logic [7:0]  eng_dbyte,
  output logic        eng_cwe,
  output logic [7:0]  eng_cnt,
  output logic        busy,
  output logic [7:0]  sts_byte
);
  localparam logic [7:0] LIM = 8'(DATA_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR1, ST_CMD, ST_CNT, ST_WDATA,
    ST_RSTART, ST_ADDR2, ST_RCNT, ST_RDATA, ST_STOP
  } st_e;

  st_e        st, after_w, after_cnt, after_cmd, rx_entry;
  xact_desc_t d;
  logic [7:0] idx, nrd_q;
  logic       done_q, hs, cnt_ok;
  logic [4:0] code_q, pend_q;

  assign hs        = op_valid && op_ready;
  assign busy      = (st != ST_IDLE);
  assign cnt_ok    = (op_rbyte != 8'd0) && (op_rbyte <= LIM);
  assign after_w   = d.rx_en ? ST_RSTART : ST_STOP;
  assign after_cnt = (d.nwr != 8'd0) ? ST_WDATA : after_w;
  assign after_cmd = d.send_cnt ? ST_CNT : after_cnt;
  assign rx_entry  = d.rx_cnt ? ST_RCNT : ((d.nrd != 8'd0) ? ST_RDATA : ST_STOP);
  assign sts_byte  = {done_q, 2'b00, code_q};
  assign tx_idx    = idx;
  assign eng_dwe   = hs && (st == ST_RDATA);
  assign eng_didx  = idx;
  assign eng_dbyte = op_rbyte;
  assign eng_cwe   = hs && (st == ST_RCNT) && cnt_ok;
  assign eng_cnt   = op_rbyte;

  always_comb begin
    op_valid = busy;
    op_kind  = OP_SEND;
    op_byte  = 8'h00;
    op_nack  = 1'b0;
    case (st)
      ST_START:  op_kind = OP_START;
      ST_ADDR1:  op_byte = {addr_q[7:1], d.first_rd};
      ST_CMD:    op_byte = cmd_q;
      ST_CNT:    op_byte = d.nwr;
      ST_WDATA:  op_byte = tx_byte;
      ST_RSTART: op_kind = OP_RSTART;
      ST_ADDR2:  op_byte = {addr_q[7:1], 1'b1};
      ST_RCNT:   op_kind = OP_RECV;
      ST_RDATA:  begin op_kind = OP_RECV; op_nack = (idx == nrd_q - 8'd1); end
      ST_STOP:   op_kind = OP_STOP;
      default:   op_kind = OP_SEND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; d <= '0; idx <= '0; nrd_q <= '0;
      done_q <= 1'b0; code_q <= RC_OK; pend_q <= RC_OK;
    end else if (launch_we && !busy) begin
      if (desc.valid) begin
        done_q <= 1'b0; code_q <= RC_OK; pend_q <= RC_OK;
        d <= desc; idx <= '0; nrd_q <= desc.nrd; st <= ST_START;
      end else begin
        done_q <= 1'b1; code_q <= RC_UNSUP;
      end
    end else begin
      if (launch_we) code_q <= RC_BUSY;
      if (hs) begin
        case (st)
          ST_START: st <= ST_ADDR1;
          ST_ADDR1: begin
            if (op_nak) begin pend_q <= RC_NAK; st <= ST_STOP; end
            else if (d.first_rd) st <= (d.rx_en && d.nrd != 8'd0) ? ST_RDATA : ST_STOP;
            else st <= d.send_cmd ? ST_CMD : after_cmd;
          end
          ST_CMD, ST_CNT: begin
            if (op_nak) begin pend_q <= RC_DEVERR; st <= ST_STOP; end
            else st <= (st == ST_CMD) ? after_cmd : after_cnt;
          end
          ST_WDATA: begin
            if (op_nak) begin pend_q <= RC_DEVERR; st <= ST_STOP; end
            else if (idx == d.nwr - 8'd1) begin idx <= '0; st <= after_w; end
            else idx <= idx + 8'd1;
          end
          ST_RSTART: st <= ST_ADDR2;
          ST_ADDR2: begin
            if (op_nak) begin pend_q <= RC_NAK; st <= ST_STOP; end
            else st <= rx_entry;
          end
          ST_RCNT: begin
            if (!cnt_ok) begin pend_q <= RC_DEVERR; st <= ST_STOP; end
            else begin nrd_q <= op_rbyte; idx <= '0; st <= ST_RDATA; end
          end
          ST_RDATA: begin
            if (idx == nrd_q - 8'd1) st <= ST_STOP;
            else idx <= idx + 8'd1;
          end
          ST_STOP: begin done_q <= 1'b1; code_q <= pend_q; st <= ST_IDLE; end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assert_op_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_byte) && $stable(op_nack)));

  assert_addr_nak_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (st == ST_ADDR1 || st == ST_ADDR2) && op_nak) |=> (op_valid && op_kind == OP_STOP));

  assert_unsup_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_we && !busy && !desc.valid) |=> (done_q && code_q == RC_UNSUP && !op_valid));

  assert_busy_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_we && busy && !(hs && st == ST_STOP)) |=> (code_q == RC_BUSY && !done_q));

  assert_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(hs && st == ST_STOP) || $past(launch_we && !busy)));
endmodule

// File: rtl/smbus_xact_engine.sv
module smbus_xact_engine
  import smbx_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  localparam int AW = $clog2(DATA_BYTES + 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_we,
  output logic [7:0]    reg_rdata,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [2:0]    op_kind,
  output logic [7:0]    op_byte,
  output logic          op_nack,
  input  logic [7:0]    op_rbyte,
  input  logic          op_nak,
  output logic          pec_req
);
  xact_desc_t desc;
  bus_op_e    kind_e;
  logic [7:0] prot_q, addr_q, cmd_q, bcnt_q, tx_idx, tx_byte, sts_byte;
  logic [7:0] eng_didx, eng_dbyte, eng_cnt;
  logic       eng_dwe, eng_cwe, busy, launch_we;

  assign launch_we = reg_we && (reg_addr == AW'(0));
  assign op_kind   = kind_e;
  assign pec_req   = busy && prot_q[7];

  smbx_decode #(.DATA_BYTES(DATA_BYTES)) u_dec (
    .code(reg_wdata), .cnt_reg(bcnt_q), .desc(desc));

  smbx_regfile #(.DATA_BYTES(DATA_BYTES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(reg_addr), .host_wdata(reg_wdata),
    .host_we(reg_we), .idle(!busy), .host_rdata(reg_rdata), .sts_byte(sts_byte),
    .prot_q(prot_q), .addr_q(addr_q), .cmd_q(cmd_q), .bcnt_q(bcnt_q),
    .tx_idx(tx_idx), .tx_byte(tx_byte), .eng_dwe(eng_dwe), .eng_didx(eng_didx),
    .eng_dbyte(eng_dbyte), .eng_cwe(eng_cwe), .eng_cnt(eng_cnt));

  smbx_seq #(.DATA_BYTES(DATA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch_we(launch_we), .desc(desc),
    .addr_q(addr_q), .cmd_q(cmd_q), .tx_byte(tx_byte), .tx_idx(tx_idx),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(kind_e), .op_byte(op_byte),
    .op_nack(op_nack), .op_rbyte(op_rbyte), .op_nak(op_nak),
    .eng_dwe(eng_dwe), .eng_didx(eng_didx), .eng_dbyte(eng_dbyte),
    .eng_cwe(eng_cwe), .eng_cnt(eng_cnt), .busy(busy), .sts_byte(sts_byte));

  assert_pec_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !pec_req);
endmodule

// File: tb/tb_smbus_xact_engine.sv
module tb_smbus_xact_engine;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0;
  logic op_valid, op_nack, pec_req;
  logic op_ready = 1'b0, op_nak = 1'b0;
  logic [2:0] op_kind;
  logic [7:0] op_byte, op_rbyte = '0;

  int checks = 0, fails = 0;
  int n_ops, n_rx, n_nack, n_addr, n_sent, dly;
  logic [7:0] addr_log [4];
  logic [7:0] sent_log [64];
  logic [7:0] rx_first;
  bit nak_addr = 0, nak_data = 0, slow = 0, expect_addr = 0;

  smbus_xact_engine dut (.*);

  always #2 clk = ~clk;

  // proto, bcnt, first received byte, expected steps, expected status
  localparam logic [39:0] VEC [22] = '{
    {8'h02, 8'h00, 8'h00, 8'd3,  8'h80}, {8'h03, 8'h00, 8'h00, 8'd3,  8'h80},
    {8'h04, 8'h00, 8'h00, 8'd4,  8'h80}, {8'h05, 8'h00, 8'h55, 8'd4,  8'h80},
    {8'h06, 8'h00, 8'h00, 8'd5,  8'h80}, {8'h07, 8'h00, 8'h55, 8'd7,  8'h80},
    {8'h08, 8'h00, 8'h00, 8'd6,  8'h80}, {8'h09, 8'h00, 8'h55, 8'd8,  8'h80},
    {8'h0A, 8'h03, 8'h00, 8'd8,  8'h80}, {8'h0B, 8'h00, 8'h02, 8'd9,  8'h80},
    {8'h0C, 8'h00, 8'h55, 8'd10, 8'h80}, {8'h0D, 8'h02, 8'h01, 8'd11, 8'h80},
    {8'h4A, 8'h02, 8'h00, 8'd6,  8'h80}, {8'h4B, 8'h03, 8'h55, 8'd9,  8'h80},
    {8'h8A, 8'h00, 8'h00, 8'd5,  8'h80}, {8'h0A, 8'h28, 8'h00, 8'd37, 8'h80},
    {8'h0D, 8'h28, 8'h01, 8'd40, 8'h80}, {8'h0B, 8'h00, 8'h00, 8'd7,  8'h91},
    {8'h0B, 8'h00, 8'h21, 8'd7,  8'h91}, {8'h01, 8'h00, 8'h00, 8'd0,  8'h99},
    {8'h4C, 8'h00, 8'h00, 8'd0,  8'h99}, {8'h8B, 8'h00, 8'h02, 8'd9,  8'h80}
  };

  function automatic string tag_of(input logic [7:0] p, input logic [7:0] b, input logic [7:0] s);
    if (s[4:0] == 5'h19) return "R13";
    if (s[4:0] == 5'h11) return "R9";
    if (b > 8'd32) return "R8";
    if (p[7]) return "R14";
    if (p[6]) return "R5";
    if (p[3:0] >= 4'hA) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = v; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    reg_addr = AW'(a);
    #1 v = reg_rdata;
  endtask

  task automatic launch(input logic [7:0] p);
    n_ops = 0; n_rx = 0; n_nack = 0; n_addr = 0; n_sent = 0; expect_addr = 0;
    wr(0, p);
  endtask

  task automatic wait_done(output logic [7:0] s);
    s = 8'h00;
    for (int i = 0; i < 3000; i++) begin
      rd(1, s);
      if (s[7]) break;
      @(negedge clk);
    end
  endtask

  // bus engine model: one step per two cycles, or stalled when slow is set
  initial begin
    forever begin
      @(negedge clk);
      if (op_ready) op_ready = 1'b0;
      else if (op_valid && rst_n) begin
        if (slow && dly < 20) dly++;
        else begin
          dly = 0;
          n_ops++;
          op_nak = 1'b0;
          case (op_kind)
            3'd0, 3'd3: expect_addr = 1;
            3'd1: begin
              if (expect_addr) begin
                if (n_addr < 4) addr_log[n_addr] = op_byte;
                n_addr++; op_nak = nak_addr; expect_addr = 0;
              end else begin
                if (n_sent < 64) sent_log[n_sent] = op_byte;
                n_sent++; op_nak = nak_data;
              end
            end
            3'd2: begin
              op_rbyte = (n_rx == 0) ? rx_first : 8'hA0 + 8'(n_rx - 1);
              n_rx++;
              if (op_nack) n_nack++;
            end
            default: ;
          endcase
          op_ready = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=no-finish expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, v;
    dly = 0; rx_first = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, v); check("R1", "reset protocol", v, 8'h00);
    rd(1, v); check("R1", "reset status", v, 8'h00);
    rd(36, v); check("R1", "reset count", v, 8'h00);

    wr(37, 8'h3C); wr(38, 8'h5A); wr(39, 8'hC3); wr(4, 8'h11); wr(35, 8'h99);
    rd(37, v); check("R1", "alarm addr", v, 8'h3C);
    rd(38, v); check("R1", "alarm data0", v, 8'h5A);
    rd(39, v); check("R1", "alarm data1", v, 8'hC3);
    rd(4, v);  check("R1", "data0", v, 8'h11);
    rd(35, v); check("R1", "data31", v, 8'h99);

    foreach (VEC[k]) begin
      wr(2, 8'hA4); wr(3, 8'h5C); wr(36, VEC[k][31:24]);
      rx_first = VEC[k][23:16];
      launch(VEC[k][39:32]);
      wait_done(s);
      check(tag_of(VEC[k][39:32], VEC[k][31:24], VEC[k][7:0]), $sformatf("vec%0d status", k), s, VEC[k][7:0]);
      check(tag_of(VEC[k][39:32], VEC[k][31:24], VEC[k][7:0]), $sformatf("vec%0d steps", k), n_ops, VEC[k][15:8]);
    end

    // R3 R6: word write carries command then low, high byte
    wr(4, 8'h11); wr(5, 8'h22); launch(8'h08); wait_done(s);
    check("R3", "word wr cmd", sent_log[0], 8'h5C);
    check("R3", "word wr lo", sent_log[1], 8'h11);
    check("R3", "word wr hi", sent_log[2], 8'h22);
    check("R6", "write addr", addr_log[0], 8'hA4);

    // R4 R8: block write count byte and data order
    wr(36, 8'd3); wr(4, 8'h10); wr(5, 8'h11); wr(6, 8'h12);
    launch(8'h0A); wait_done(s);
    check("R8", "count byte", sent_log[1], 8'h03);
    check("R4", "last block byte", sent_log[4], 8'h12);
    wr(36, 8'd40); launch(8'h0D); rx_first = 8'h01; wait_done(s);
    check("R8", "block proc count", sent_log[1], 8'd31);

    // R6 R7: byte data read
    rx_first = 8'h55; launch(8'h07); wait_done(s);
    check("R6", "addr1 dir", addr_log[0], 8'hA4);
    check("R6", "addr2 dir", addr_log[1], 8'hA5);
    rd(4, v); check("R7", "byte read data", v, 8'h55);
    check("R7", "nack count", n_nack, 1);

    // R7: word read lands low byte first
    rx_first = 8'h34; launch(8'h09); wait_done(s);
    rd(4, v); check("R7", "word lo", v, 8'h34);
    rd(5, v); check("R7", "word hi", v, 8'hA0);
    check("R7", "word nack count", n_nack, 1);

    // R9: received block count stored, bytes placed
    wr(36, 8'd0); rx_first = 8'h02; launch(8'h0B); wait_done(s);
    rd(36, v); check("R9", "rx count", v, 8'h02);
    rd(4, v);  check("R9", "rx block0", v, 8'hA0);
    rd(5, v);  check("R9", "rx block1", v, 8'hA1);
    check("R7", "block nack count", n_nack, 1);

    // R10: address and data not acknowledged
    nak_addr = 1; launch(8'h07); wait_done(s); nak_addr = 0;
    check("R10", "addr nak status", s, 8'h90);
    check("R10", "addr nak steps", n_ops, 3);
    nak_data = 1; launch(8'h06); wait_done(s); nak_data = 0;
    check("R10", "data nak status", s, 8'h91);
    check("R10", "data nak steps", n_ops, 4);

    // R11 R12 R2: busy write during a stalled run
    slow = 1; wr(36, 8'd32); launch(8'h0A);
    rd(1, v); check("R11", "done cleared at launch", v, 8'h00);
    repeat (10) @(negedge clk);
    wr(0, 8'h02);
    rd(1, v); check("R12", "busy code", v, 8'h1A);
    rd(0, v); check("R12", "protocol unchanged", v, 8'h0A);
    wait_done(s);
    check("R12", "run completes", s, 8'h80);
    check("R2", "stalled steps", n_ops, 37);

    // R14: PEC request follows bit 7 during the run
    launch(8'h88);
    repeat (10) @(negedge clk);
    #1 check("R14", "pec during run", pec_req, 1);
    wait_done(s);
    #1 check("R14", "pec after run", pec_req, 0);
    slow = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule